// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block is a purely combinational two's-complement adder. It takes two operands and a carry-in and returns the sum, the carry-out and a signed overflow flag. The operand width is split into ripple-carry groups. Each group has its own chain, a wide AND of its per-bit propagate terms, and a two-input multiplexer. When every bit of a group propagates, that multiplexer passes the group's incoming carry straight to the next group, so the carry does not ripple through the group's bits.

The group widths come from a parameter array. The default profile for 32 bits is 2, 4, 6, 8, 6, 4, 2: narrow groups at both ends and wide groups in the middle. The worst path is therefore the ripple and skip of the lowest group, then the skip multiplexers of the inner groups, then the ripple of the top group. Per-bit propagate (XOR), per-bit generate (AND) and group-propagate terms depend only on the operands. They are formed in parallel with the carries. The block is meant to sit in front of a register stage inside a larger datapath.

Top module: `csk_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i`.
- R2: `carry_o` equals bit WIDTH of `a_i + b_i + carry_i`.
- R3: `ovf_o` is 1 exactly when `a_i[WIDTH-1] == b_i[WIDTH-1]` and `sum_o[WIDTH-1]` differs from them.
- R4: When a group's operand bits all differ (`a_i ^ b_i` all ones over that group), the carry leaving the group equals the carry entering it. At the ports, `a_i ^ b_i` all ones gives `carry_o == carry_i`.
- R5: The group widths must sum exactly to WIDTH, and a mismatch stops elaboration. With the default 2,4,6,8,6,4,2 partition, a carry generated at any bit position reaches every higher bit and `carry_o` correctly.
- R6: Outputs depend only on the present inputs, with no clock or state, so a result is valid in the same cycle its inputs are applied.
- R7: With `a_i` all ones, `b_i` zero and `carry_i` = 1, the carry crosses the full skip path: `sum_o` = 0, `carry_o` = 1, `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| carry_i | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH | sum bits |
| carry_o | output | 1 | carry out of the top bit |
| ovf_o | output | 1 | two's-complement overflow |

## Verification
The adder holds no state, so every result is due zero cycles after its stimulus. Only settling through the gates is needed. The bench applies operands on the falling clock edge and samples all three outputs one nanosecond later, well before the next rising edge. It never compares against a value from an earlier cycle. Because each vector is checked on its own, random vectors and directed corner cases can be interleaved freely.

// File: rtl/csk_pkg.sv
package csk_pkg;
  typedef struct packed {
    logic p;  // a ^ b
    logic g;  // a & b
  } pg_t;
endpackage

// File: rtl/csk_pg.sv
module csk_pg
  import csk_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output pg_t  [WIDTH-1:0] pg_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pg_o[i].p = a_i[i] ^ b_i[i];
    assign pg_o[i].g = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/csk_block.sv
module csk_block
  import csk_pkg::*;
#(
  parameter int BW = 4
) (
  input  pg_t  [BW-1:0] pg_i,
  input  logic          cin_i,
  output logic [BW-1:0] cbit_o,  // carry into each bit
  output logic          grp_p_o,
  output logic          cout_o
);
  logic [BW:0] rc;
  logic [BW-1:0] p_vec;

  assign rc[0] = cin_i;
  for (genvar i = 0; i < BW; i++) begin : g_rip
    assign rc[i+1]  = pg_i[i].g | (pg_i[i].p & rc[i]);
    assign p_vec[i] = pg_i[i].p;
  end

  assign cbit_o  = rc[BW-1:0];
  assign grp_p_o = &p_vec;
  // skip mux: bypass the chain when the whole group propagates
  assign cout_o  = grp_p_o ? cin_i : rc[BW];
endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter int NUM_BLK        = 7,
  parameter int BLK_W [NUM_BLK] = '{2, 4, 6, 8, 6, 4, 2}
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  function automatic int blk_lo(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += BLK_W[j];
    return s;
  endfunction

  localparam int TOTAL_W = blk_lo(NUM_BLK);

  if (TOTAL_W != WIDTH) begin : g_bad_part
    $error("csk_adder: group widths do not sum to WIDTH");
  end

  pg_t  [WIDTH-1:0]   pg;
  logic [WIDTH-1:0]   cbit;
  logic [NUM_BLK-1:0] blk_ci;
  logic [NUM_BLK-1:0] blk_co;
  logic [NUM_BLK-1:0] blk_prop;

  csk_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .pg_o(pg)
  );

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    localparam int LO = blk_lo(k);
    localparam int BW = BLK_W[k];

    if (k == 0) begin : g_first
      assign blk_ci[k] = carry_i;
    end else begin : g_next
      assign blk_ci[k] = blk_co[k-1];
    end

    csk_block #(.BW(BW)) u_blk (
      .pg_i   (pg[LO+BW-1:LO]),
      .cin_i  (blk_ci[k]),
      .cbit_o (cbit[LO+BW-1:LO]),
      .grp_p_o(blk_prop[k]),
      .cout_o (blk_co[k])
    );
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = pg[i].p ^ cbit[i];
  end

  assign carry_o = blk_co[NUM_BLK-1];
  assign ovf_o   = cbit[WIDTH-1] ^ blk_co[NUM_BLK-1];
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
  parameter int WIDTH   = 32,
  parameter int NUM_BLK = 7
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               carry_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               carry_o,
  input logic               ovf_o,
  input logic [NUM_BLK-1:0] blk_ci,
  input logic [NUM_BLK-1:0] blk_co,
  input logic [NUM_BLK-1:0] blk_prop
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

  always_comb begin
    // R1
    sum_val_chk: assert (sum_o == ref_sum[WIDTH-1:0]);
    // R2
    carry_val_chk: assert (carry_o == ref_sum[WIDTH]);
    // R3
    ovf_val_chk: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                                   (sum_o[WIDTH-1] != a_i[WIDTH-1])));
    // R4
    full_skip_chk: assert (!(&(a_i ^ b_i)) || (carry_o == carry_i));
    for (int k = 0; k < NUM_BLK; k++) begin
      // R4
      blk_skip_chk: assert (!blk_prop[k] || (blk_co[k] == blk_ci[k]));
    end
  end
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .NUM_BLK(NUM_BLK)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .carry_i (carry_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .blk_ci  (blk_ci),
  .blk_co  (blk_co),
  .blk_prop(blk_prop)
);

// File: tb/csk_adder_test.sv
`timescale 1ns/1ps
module csk_adder_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] a, b, s;
  logic         ci, co, ov;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  csk_adder uut (
    .a_i(a), .b_i(b), .carry_i(ci),
    .sum_o(s), .carry_o(co), .ovf_o(ov)
  );

  function automatic logic [W:0] exp_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic exp_ovf(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] r);
    return (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
  endfunction

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", req, a, b, ci, act, exp);
    end
  endtask

  // R6: drive on falling edge, sample 1 ns later in the same cycle
  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
    e = exp_add(x, y, c);
    chk("R1", {1'b0, s}, {1'b0, e[W-1:0]});
    chk("R2", {{W{1'b0}}, co}, {{W{1'b0}}, e[W]});
    chk("R3", {{W{1'b0}}, ov}, {{W{1'b0}}, exp_ovf(x, y, e[W-1:0])});
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R6: zero inputs give zero outputs
    #1;
    chk("R6", {co, s}, '0);
    chk("R6", {{W{1'b0}}, ov}, '0);

    // R7: full skip path
    apply('1, '0, 1'b1);
    chk("R7", {co, s}, {1'b1, {W{1'b0}}});
    chk("R7", {{W{1'b0}}, ov}, '0);

    // R4: every bit propagates, both carry-in values
    apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0);
    chk("R4", {{W{1'b0}}, co}, '0);
    apply(32'h0F0F_1234, ~32'h0F0F_1234, 1'b1);
    chk("R4", {co, s}, {1'b1, {W{1'b0}}});

    // R3 corners
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    chk("R3", {{W{1'b0}}, ov}, {{W{1'b0}}, 1'b1});
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R3", {{W{1'b0}}, ov}, {{W{1'b0}}, 1'b1});
    apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
    chk("R3", {{W{1'b0}}, ov}, '0);

    // R5: generate at each bit, propagate above it, across every group edge
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] ones_hi;
      ones_hi = '1 << k;
      apply(ones_hi, 32'(1) << k, 1'b0);
      chk("R5", {co, s}, {1'b1, {W{1'b0}}});
    end

    // random mix
    void'($urandom(32'h0C5A_0001));
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (n % 7 == 0) y = ~x;
      apply(x, y, 1'($urandom()));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule